// File: doc/BRIEF.md
# Wavetable Sample Store with Playback Reader

This block holds the waveform of a wavetable sound channel: sixteen bytes, each packing two 4-bit samples, for a cycle of thirty-two samples. A processor reaches the bytes through a simple one-cycle port. A playback reader walks a 5-bit sample index forward on each tick and presents the selected sample on a 4-bit output. The pitch generator, level scaling, length counter and converter around it are outside the block. Their only contact with it is the tick input and the sample output.

The `active` input decides who owns the byte select. While the channel is idle, the processor reaches the byte it addresses. While the channel plays, the reader owns the select. Any processor read or write then lands on the byte the reader is on, and the supplied address is ignored. A `start` pulse rewinds the index to 0. Because the first tick moves the index straight to 1, the first sample heard is the lower half of byte 0.

A small sequencer tracks the playback phase. It has three states:

- `ST_IDLE`: the channel is not running.
- `ST_PRIMED`: the block has been rewound and is waiting for its first tick.
- `ST_RUN`: the block is stepping through samples.

It has these transitions:

- `start` in any state moves to `ST_PRIMED`.
- An advancing tick moves `ST_IDLE` or `ST_PRIMED` to `ST_RUN`.
- `ST_RUN` falls back to `ST_IDLE` when `active` drops.

Top module: `wavetable_sample_store`

## Requirements
- R1: After reset, every byte reads 0x00. The sample index is 0, `sample_out` is 0, `cpu_rdata` is 0 and the sequencer is in `ST_IDLE`.
- R2: Sample k lives in byte k>>1. An even k takes bits [7:4] of the byte and an odd k takes bits [3:0], so playback order is byte 0 upper, byte 0 lower, byte 1 upper, and so on up to byte 15 lower.
- R3: A cycle with `active`=1, `tick`=1 and `start`=0 advances the index by one, wrapping from 31 to 0. On the following cycle, `sample_out` shows the sample at the new index.
- R4: `start` sets the index to 0 on the next cycle, whatever `tick` does in that cycle, and leaves `sample_out` unchanged. The first advancing tick after it produces sample 1, the lower nibble of byte 0.
- R5: With `active`=1, a processor write (`cpu_en`=1, `cpu_we`=1) stores `cpu_wdata` into byte index[4:1], ignoring `cpu_addr`.
- R6: With `active`=1, a processor read (`cpu_en`=1, `cpu_we`=0) returns byte index[4:1] on `cpu_rdata` one cycle later, ignoring `cpu_addr`.
- R7: With `active`=0, processor writes store into byte `cpu_addr`. Reads return byte `cpu_addr` on `cpu_rdata` one cycle later.
- R8: With `active`=0, `tick` has no effect: the index and `sample_out` hold.
- R9: When a playback write and an advancing tick share a cycle, the write lands in the byte of the index before it advances. `sample_out` is taken from the byte contents before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| active | input | 1 | Channel playing; gives the reader ownership of the byte select |
| start | input | 1 | One-cycle pulse that rewinds the sample index to 0 |
| tick | input | 1 | Playback step request |
| cpu_en | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read (qualified by cpu_en) |
| cpu_addr | input | 4 | Processor byte address (used only when idle) |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, registered, held between reads |
| sample_out | output | 4 | Current playback sample, held while idle |

## Verification
The bench runs a full lap of 33 ticks after a start pulse. A reader that began at sample 0, swapped the nibble halves, or failed to wrap at 31 shows a wrong nibble at once. It writes and reads during playback with an address far from the reader's byte, then checks both bytes once idle. A design that honoured the processor address would corrupt the wrong byte and leave the reader's byte untouched. It also collides a write with a tick on an even index, where the old and new index share a byte. A design that wrote after advancing, or fed the fresh write into the sample, would give a different byte or nibble. Finally, it checks that ticks while idle are ignored and that a start beats a simultaneous tick, since either slip shifts every later sample by one.

// File: rtl/wss_pkg.sv
package wss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIMED = 2'd1,
        ST_RUN    = 2'd2
    } wss_state_e;

    // Two samples per byte: upper half first, lower half second.
    function automatic logic [3:0] pick_nibble(input logic [7:0] byte_v, input logic lsb);
        return lsb ? byte_v[3:0] : byte_v[7:4];
    endfunction

endpackage

// File: rtl/wss_sequencer.sv
module wss_sequencer
    import wss_pkg::*;
#(
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            active_i,
    input  logic            tick_i,
    output logic [IDXW-1:0] idx_o,
    output wss_state_e      state_o,
    output logic            adv_o
);

    wss_state_e      state_q;
    wss_state_e      state_d;
    logic [IDXW-1:0] idx_q;

    // An advancing step: channel running, tick present, no rewind.
    always_comb begin
        adv_o = active_i && tick_i && !start_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)    state_d = ST_PRIMED;
                else if (adv_o) state_d = ST_RUN;
            end
            ST_PRIMED: begin
                if (start_i)    state_d = ST_PRIMED;
                else if (adv_o) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (start_i)        state_d = ST_PRIMED;
                else if (!active_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: sample index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (start_i) idx_q <= '0;
        else if (adv_o)   idx_q <= idx_q + 1'b1;
    end

    assign idx_o   = idx_q;
    assign state_o = state_q;

endmodule

// File: rtl/wss_port_mux.sv
module wss_port_mux #(
    parameter int AW   = 4,
    parameter int IDXW = 5
) (
    input  logic            active_i,
    input  logic [AW-1:0]   cpu_addr_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic            cpu_en_i,
    input  logic            cpu_we_i,
    output logic [AW-1:0]   sel_o,
    output logic            wr_o,
    output logic            rd_o
);

    // The reader wins the byte select whenever the channel is running.
    always_comb begin
        sel_o = active_i ? idx_i[IDXW-1:1] : cpu_addr_i;
        wr_o  = cpu_en_i && cpu_we_i;
        rd_o  = cpu_en_i && !cpu_we_i;
    end

endmodule

// File: rtl/wss_storage.sv
module wss_storage #(
    parameter int NBYTES = 16,
    parameter int DW     = 8,
    parameter int AW     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [AW-1:0]              waddr_i,
    input  logic [DW-1:0]              wdata_i,
    output logic [NBYTES-1:0][DW-1:0]  store_o
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [DW-1:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            byte_q <= '0;
            else if (we_i && (waddr_i == AW'(b)))  byte_q <= wdata_i;
        end

        assign store_o[b] = byte_q;
    end

endmodule

// File: rtl/wavetable_sample_store.sv
module wavetable_sample_store
    import wss_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int DW     = 8,
    parameter int SW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          start,
    input  logic          tick,
    input  logic          cpu_en,
    input  logic          cpu_we,
    input  logic [$clog2(NBYTES)-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic [SW-1:0] sample_out
);

    localparam int AW   = $clog2(NBYTES);
    localparam int IDXW = AW + 1;

    logic [IDXW-1:0]            seq_idx;
    logic [IDXW-1:0]            nxt_idx;
    wss_state_e                 seq_state;
    logic                       seq_adv;
    logic [AW-1:0]              sel;
    logic                       wr;
    logic                       rd;
    logic [NBYTES-1:0][DW-1:0]  store_q;
    logic [DW-1:0]              nxt_byte;
    logic [DW-1:0]              rdata_q;
    logic [SW-1:0]              sample_q;

    wss_sequencer #(.IDXW(IDXW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .active_i (active),
        .tick_i   (tick),
        .idx_o    (seq_idx),
        .state_o  (seq_state),
        .adv_o    (seq_adv)
    );

    wss_port_mux #(.AW(AW), .IDXW(IDXW)) u_mux (
        .active_i   (active),
        .cpu_addr_i (cpu_addr),
        .idx_i      (seq_idx),
        .cpu_en_i   (cpu_en),
        .cpu_we_i   (cpu_we),
        .sel_o      (sel),
        .wr_o       (wr),
        .rd_o       (rd)
    );

    wss_storage #(.NBYTES(NBYTES), .DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr),
        .waddr_i (sel),
        .wdata_i (cpu_wdata),
        .store_o (store_q)
    );

    // The sample after a step comes from the pre-write contents.
    assign nxt_idx  = seq_idx + 1'b1;
    assign nxt_byte = store_q[nxt_idx[IDXW-1:1]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sample_q <= '0;
        else if (seq_adv) sample_q <= pick_nibble(nxt_byte, nxt_idx[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= store_q[sel];
    end

    assign cpu_rdata  = rdata_q;
    assign sample_out = sample_q;

endmodule

// File: rtl/wss_checker.sv
module wss_checker
    import wss_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int DW     = 8,
    parameter int SW     = 4,
    parameter int AW     = 4,
    parameter int IDXW   = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      active,
    input logic                      start,
    input logic                      tick,
    input logic                      cpu_en,
    input logic                      cpu_we,
    input logic [AW-1:0]             cpu_addr,
    input logic [DW-1:0]             cpu_wdata,
    input logic [DW-1:0]             cpu_rdata,
    input logic [SW-1:0]             sample_out,
    input logic [IDXW-1:0]           idx,
    input wss_state_e                state,
    input logic [NBYTES-1:0][DW-1:0] store
);

    logic [AW-1:0] last_play_byte;
    logic [AW-1:0] last_cpu_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_play_byte <= '0;
            last_cpu_addr  <= '0;
        end else begin
            last_play_byte <= idx[IDXW-1:1];
            last_cpu_addr  <= cpu_addr;
        end
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !start) |=> (idx == IDXW'($past(idx) + 1'b1)));

    assert_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (idx == '0 && state == ST_PRIMED && $stable(sample_out)));

    assert_primed_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMED) |-> (idx == '0));

    assert_first_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIMED && active && tick && !start) |=> (sample_out == $past(store[0][SW-1:0])));

    assert_play_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cpu_en && cpu_we) |=> (store[last_play_byte] == $past(cpu_wdata)));

    assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && cpu_en && !cpu_we) |=> (cpu_rdata == store[last_cpu_addr]));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> ($stable(idx) && $stable(sample_out)));

endmodule

bind wavetable_sample_store wss_checker #(
    .NBYTES (NBYTES),
    .DW     (DW),
    .SW     (SW),
    .AW     (AW),
    .IDXW   (IDXW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .start      (start),
    .tick       (tick),
    .cpu_en     (cpu_en),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .sample_out (sample_out),
    .idx        (seq_idx),
    .state      (seq_state),
    .store      (store_q)
);

// File: tb/wavetable_sample_store_tb.sv
module wavetable_sample_store_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       active = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic       cpu_en = 1'b0;
    logic       cpu_we = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [3:0] sample_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] mdl [16];
    logic [4:0] midx = '0;
    logic [3:0] msample = '0;

    always #10 clk = ~clk;

    wavetable_sample_store u_dut (
        .clk(clk), .rst_n(rst_n), .active(active), .start(start), .tick(tick),
        .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .sample_out(sample_out)
    );

    function automatic logic [3:0] nib(input logic [4:0] k);
        return k[0] ? mdl[k[4:1]][3:0] : mdl[k[4:1]][7:4];
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d);
        cpu_en = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        step();
        mdl[active ? midx[4:1] : a] = d;
        cpu_en = 0; cpu_we = 0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [7:0] d);
        cpu_en = 1; cpu_we = 0; cpu_addr = a;
        step();
        d = cpu_rdata;
        cpu_en = 0;
    endtask

    task automatic do_tick();
        tick = 1;
        step();
        if (active) begin
            midx = midx + 1'b1;
            msample = nib(midx);
        end
        tick = 0;
    endtask

    task automatic do_start();
        start = 1;
        step();
        midx = '0;
        start = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 sample_out", {4'h0, sample_out}, 8'h00);
        check("R1 rdata", cpu_rdata, 8'h00);
        do_read(4'd5, d);
        check("R1 byte5", d, 8'h00);
        do_read(4'd15, d);
        check("R1 byte15", d, 8'h00);
    endtask

    task automatic t_idle_access();
        logic [7:0] d;
        active = 0;
        for (int i = 0; i < 16; i++) do_write(4'(i), 8'((i * 8'h1D) ^ 8'hC3));
        for (int i = 15; i >= 0; i--) begin
            do_read(4'(i), d);
            check("R7 idle read", d, mdl[i]);
        end
        step();
        check("R7 rdata held", cpu_rdata, mdl[0]);
    endtask

    task automatic t_full_lap();
        active = 1;
        do_start();
        check("R4 sample unchanged by start", {4'h0, sample_out}, 8'h00);
        for (int t = 1; t <= 33; t++) begin
            do_tick();
            check((t == 1) ? "R4 first sample is index 1" : "R2 R3 playback order",
                  {4'h0, sample_out}, {4'h0, nib(5'(t % 32))});
        end
    endtask

    task automatic t_redirect();
        logic [7:0] d;
        logic [7:0] keep13;
        active = 1;
        do_start();
        for (int t = 0; t < 5; t++) do_tick();
        keep13 = mdl[13];
        do_read(4'd13, d);
        check("R6 play read redirected", d, mdl[2]);
        do_write(4'd13, 8'h3C);
        active = 0;
        step();
        do_read(4'd2, d);
        check("R5 play write to reader byte", d, 8'h3C);
        do_read(4'd13, d);
        check("R5 addressed byte untouched", d, keep13);
    endtask

    task automatic t_idle_ticks();
        logic [3:0] held;
        active = 1;
        do_tick();
        held = sample_out;
        active = 0;
        for (int t = 0; t < 3; t++) begin
            do_tick();
            check("R8 idle tick ignored", {4'h0, sample_out}, {4'h0, held});
        end
        active = 1;
        do_tick();
        check("R8 index held across idle", {4'h0, sample_out}, {4'h0, nib(midx)});
    endtask

    task automatic t_collide();
        logic [7:0] d;
        logic [7:0] old1;
        logic [7:0] keep9;
        active = 1;
        do_start();
        do_tick();
        do_tick();
        old1 = mdl[1];
        keep9 = mdl[9];
        cpu_en = 1; cpu_we = 1; cpu_addr = 4'd9; cpu_wdata = 8'hA5; tick = 1;
        step();
        cpu_en = 0; cpu_we = 0; tick = 0;
        mdl[1] = 8'hA5;
        midx = 5'd3;
        check("R9 sample from pre-write data", {4'h0, sample_out}, {4'h0, old1[3:0]});
        active = 0;
        step();
        do_read(4'd1, d);
        check("R9 write hit pre-advance byte", d, 8'hA5);
        do_read(4'd9, d);
        check("R9 other byte untouched", d, keep9);
        do_read(4'd2, d);
        check("R9 next byte untouched", d, mdl[2]);
    endtask

    task automatic t_start_beats_tick();
        active = 1;
        do_tick();
        do_tick();
        msample = sample_out;
        start = 1; tick = 1;
        step();
        start = 0; tick = 0;
        midx = '0;
        check("R4 start with tick holds sample", {4'h0, sample_out}, {4'h0, msample});
        do_tick();
        check("R4 start beats tick", {4'h0, sample_out}, {4'h0, nib(5'd1)});
        active = 0;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_idle_access();
        t_full_lap();
        t_redirect();
        t_idle_ticks();
        t_collide();
        t_start_beats_tick();
        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

endmodule